// File: doc/BRIEF.md
# CAN Controller Low-Power Mode Sequencer

This block sequences a CAN controller into and out of its two low-power modes. Software enters the module-disable mode by setting a control bit. The system stop mode is entered through a global request line and answered with an acknowledge line. In both cases the sequencer waits for a safe point on the bus and then for the engine's internal buffer traffic to finish. Only then does it gate the protocol-engine and host-interface clock enables, park the transmit pin recessive, hide the receive pin from the engine and raise its status flags.

When a stop request arrives while freeze is already acknowledged, the block takes a shortcut. It goes straight to low power, swaps the freeze acknowledge for the low-power acknowledge and then acknowledges the stop. On exit the block drops the low-power acknowledge. It then counts consecutive recessive bit samples until it has seen a full idle gap on the bus, and only then lets the engine rejoin traffic. While disabled, it screens the register path so that the protected address windows (mask and FIFO-info registers, message-buffer RAM and its reserved words) cannot be touched.

Top module: `can_lp_seq`

## Requirements
- R1: A low-power request (disable bit or stop request) taken while running does not complete entry until at least one of these inputs is seen high: engine idle, bus-off, or third intermission bit sampled recessive. With none of them high, the low-power acknowledge stays low for as long as the request is held.
- R2: After the boundary condition, entry also waits until all four busy inputs (arbitration, matching, move-in in progress, move-out in progress) are low. With a boundary present and no busy input, the low-power acknowledge rises on the third clock edge after the request is first sampled.
- R3: While in low power, the transmit pin is driven 1 (recessive) whatever the engine drives, the receive value passed to the engine is 1 whatever the pin carries, and both clock enables are 0.
- R4: On the edge that enters low power, the not-ready flag and the low-power acknowledge both become 1.
- R5: The stop acknowledge rises one edge after the low-power acknowledge, and only while the stop request is high. It falls on the edge after the stop request falls.
- R6: While freeze is acknowledged (the freeze acknowledge follows the freeze request one edge later while running), a stop request enters low power on the next edge regardless of bus position or busy inputs. On that edge the freeze acknowledge clears and the low-power acknowledge sets. The stop acknowledge follows one edge later.
- R7: Only in module-disable low power, register accesses inside the protected windows are blocked: reads return 0, no read or write reaches memory, and the access-error output is 1 during the access. With default parameters, the windows are addresses 0x010–0x01F and 0x080–0x47F of a 12-bit space. In stop mode and while running, all accesses pass through.
- R8: The low-power acknowledge clears on the first edge at which both the disable bit and the stop request are sampled low.
- R9: After exit, the block rejoins the bus only after 11 consecutive recessive samples, taken on cycles with the bit strobe high. A dominant sample on a strobe restarts the count, and samples without a strobe are ignored.
- R10: The not-ready flag clears on the edge of the 11th recessive sample when neither a freeze nor a low-power request is active. Otherwise it stays set until those requests are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_req | input | 1 | Module-disable control bit from software |
| stop_req | input | 1 | Global stop request |
| frz_req | input | 1 | Freeze request |
| eng_idle | input | 1 | Protocol engine is idle |
| eng_busoff | input | 1 | Protocol engine is bus-off |
| ims3_rec | input | 1 | Third intermission bit sampled recessive |
| busy_arb | input | 1 | Arbitration in progress |
| busy_match | input | 1 | Matching in progress |
| busy_move_in | input | 1 | Move-in in progress (a pending, unstarted one is not signalled) |
| busy_move_out | input | 1 | Move-out in progress |
| bit_stb | input | 1 | Bit-sample strobe |
| rx_pin | input | 1 | CAN receive pin |
| tx_eng | input | 1 | Transmit value from the engine |
| rx_eng | output | 1 | Receive value delivered to the engine |
| tx_pin | output | 1 | CAN transmit pin |
| pe_clk_en | output | 1 | Protocol-engine clock enable |
| host_clk_en | output | 1 | Host-interface clock enable |
| not_rdy | output | 1 | Not-ready status flag |
| lpm_ack | output | 1 | Low-power acknowledge status flag |
| frz_ack | output | 1 | Freeze acknowledge status flag |
| stop_ack | output | 1 | Stop acknowledge to the system |
| reg_rd | input | 1 | Register-path read strobe |
| reg_wr | input | 1 | Register-path write strobe |
| reg_addr | input | ADDR_W | Register-path address |
| mem_rdata | input | DATA_W | Read data from the register/RAM space |
| mem_rd | output | 1 | Read forwarded to the space |
| mem_wr | output | 1 | Write forwarded to the space |
| rdata | output | DATA_W | Read data returned to the host |
| acc_err | output | 1 | Blocked-access error |

## Verification
The bench builds the block with its default parameters: a 12-bit address space, 32-bit data, an 11-bit idle gap and two protected windows. The 12-bit space is small enough to sweep every address for both reads and writes in disable mode, stop mode and run mode. The three boundary inputs and four busy inputs give 128 entry patterns, and all of them are tried. An 11-bit gap lets the bench place a dominant sample at every position of the count.

// File: rtl/can_lp_pkg.sv
`timescale 1ns/1ps
package can_lp_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_BND    = 3'd1,
        ST_DRAIN  = 3'd2,
        ST_LP     = 3'd3,
        ST_RESYNC = 3'd4
    } lp_state_e;

    typedef struct packed {
        logic idle;
        logic busoff;
        logic ims3_rec;
    } bus_pos_t;

    typedef struct packed {
        logic arb;
        logic match;
        logic move_in;
        logic move_out;
    } eng_busy_t;

    function automatic logic at_boundary(input bus_pos_t p);
        return p.idle | p.busoff | p.ims3_rec;
    endfunction

    function automatic logic is_drained(input eng_busy_t b);
        return ~|b;
    endfunction

endpackage

// File: rtl/can_lp_resync.sv
`timescale 1ns/1ps
module can_lp_resync #(
    parameter int RESYNC_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bit_stb,
    input  logic rx_pin,
    output logic done
);
    localparam int CNT_W = $clog2(RESYNC_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RESYNC_BITS - 1);

    logic [CNT_W-1:0] cnt;

    assign done = !clr && bit_stb && rx_pin && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (bit_stb) begin
            if (!rx_pin)        cnt <= '0;
            else if (cnt != LAST) cnt <= cnt + 1'b1;
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R9
    dominant_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && bit_stb && !rx_pin) |=> (cnt == '0));

endmodule

// File: rtl/can_lp_guard.sv
`timescale 1ns/1ps
module can_lp_guard #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int RGN_N  = 2,
    parameter logic [RGN_N*ADDR_W-1:0] RGN_LO = '0,
    parameter logic [RGN_N*ADDR_W-1:0] RGN_HI = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              block_en,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              acc_err
);
    logic [RGN_N-1:0] hit;

    for (genvar g = 0; g < RGN_N; g++) begin : g_rgn
        localparam logic [ADDR_W-1:0] LO = RGN_LO[g*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] HI = RGN_HI[g*ADDR_W +: ADDR_W];
        assign hit[g] = (reg_addr >= LO) && (reg_addr <= HI);
    end

    logic stop_it;
    assign stop_it = block_en && (|hit);

    assign mem_rd  = reg_rd && !stop_it;
    assign mem_wr  = reg_wr && !stop_it;
    assign rdata   = stop_it ? '0 : mem_rdata;
    assign acc_err = stop_it && (reg_rd || reg_wr);

    // R7
    blocked_access_chk: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> (!mem_wr && !mem_rd && rdata == '0));

endmodule

// File: rtl/can_lp_seq.sv
`timescale 1ns/1ps
module can_lp_seq
    import can_lp_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int RESYNC_BITS = 11,
    parameter int RGN_N       = 2,
    parameter logic [RGN_N*ADDR_W-1:0] RGN_LO = {12'h080, 12'h010},
    parameter logic [RGN_N*ADDR_W-1:0] RGN_HI = {12'h47F, 12'h01F}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dis_req,
    input  logic              stop_req,
    input  logic              frz_req,
    input  logic              eng_idle,
    input  logic              eng_busoff,
    input  logic              ims3_rec,
    input  logic              busy_arb,
    input  logic              busy_match,
    input  logic              busy_move_in,
    input  logic              busy_move_out,
    input  logic              bit_stb,
    input  logic              rx_pin,
    input  logic              tx_eng,
    output logic              rx_eng,
    output logic              tx_pin,
    output logic              pe_clk_en,
    output logic              host_clk_en,
    output logic              not_rdy,
    output logic              lpm_ack,
    output logic              frz_ack,
    output logic              stop_ack,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              acc_err
);
    lp_state_e state;
    bus_pos_t  pos;
    eng_busy_t busy;
    logic      lp_req, in_lp, quiet, resync_done;

    assign pos    = '{idle: eng_idle, busoff: eng_busoff, ims3_rec: ims3_rec};
    assign busy   = '{arb: busy_arb, match: busy_match,
                      move_in: busy_move_in, move_out: busy_move_out};
    assign lp_req = dis_req || stop_req;
    assign in_lp  = (state == ST_LP);
    assign quiet  = in_lp || (state == ST_RESYNC);

    assign tx_pin      = quiet ? 1'b1 : tx_eng;
    assign rx_eng      = quiet ? 1'b1 : rx_pin;
    assign pe_clk_en   = !in_lp;
    assign host_clk_en = !in_lp;

    can_lp_resync #(.RESYNC_BITS(RESYNC_BITS)) i_resync (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_RESYNC),
        .bit_stb (bit_stb),
        .rx_pin  (rx_pin),
        .done    (resync_done)
    );

    can_lp_guard #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RGN_N  (RGN_N),
        .RGN_LO (RGN_LO),
        .RGN_HI (RGN_HI)
    ) i_guard (
        .clk       (clk),
        .rst       (rst),
        .block_en  (in_lp && dis_req),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .rdata     (rdata),
        .acc_err   (acc_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            not_rdy  <= 1'b0;
            lpm_ack  <= 1'b0;
            frz_ack  <= 1'b0;
            stop_ack <= 1'b0;
        end else begin
            stop_ack <= in_lp && lpm_ack && stop_req;
            frz_ack  <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    frz_ack <= frz_req;
                    if (stop_req && frz_ack) begin
                        state   <= ST_LP;
                        lpm_ack <= 1'b1;
                        not_rdy <= 1'b1;
                        frz_ack <= 1'b0;
                    end else if (lp_req) begin
                        state <= ST_BND;
                    end else if (!frz_req) begin
                        not_rdy <= 1'b0;
                    end
                end
                ST_BND: begin
                    if (!lp_req)               state <= ST_RUN;
                    else if (at_boundary(pos)) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!lp_req) begin
                        state <= ST_RUN;
                    end else if (is_drained(busy)) begin
                        state   <= ST_LP;
                        lpm_ack <= 1'b1;
                        not_rdy <= 1'b1;
                    end
                end
                ST_LP: begin
                    if (!lp_req) begin
                        state   <= ST_RESYNC;
                        lpm_ack <= 1'b0;
                    end
                end
                ST_RESYNC: begin
                    if (lp_req) begin
                        state   <= ST_LP;
                        lpm_ack <= 1'b1;
                    end else if (resync_done) begin
                        state   <= ST_RUN;
                        not_rdy <= frz_req;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // R3
    lp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        lpm_ack |-> (tx_pin && rx_eng && !pe_clk_en && !host_clk_en));

    // R4
    lp_flags_chk: assert property (@(posedge clk) disable iff (rst)
        lpm_ack |-> not_rdy);

    // R5
    stop_ack_order_chk: assert property (@(posedge clk) disable iff (rst)
        stop_ack |-> (lpm_ack && not_rdy && $past(lpm_ack) && $past(stop_req)));

    // R2
    drain_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lpm_ack) |-> ($past(frz_ack) || $past(is_drained(busy))
                            || $past(state == ST_RESYNC)));

    // R6
    frz_swap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(lpm_ack) && $past(frz_ack)) |-> !frz_ack);

    // R8
    exit_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (lpm_ack && !dis_req && !stop_req) |=> !lpm_ack);

endmodule

// File: tb/test_can_lp_seq.sv
`timescale 1ns/1ps
module test_can_lp_seq;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dis_req = 0, stop_req = 0, frz_req = 0;
    logic eng_idle = 1, eng_busoff = 0, ims3_rec = 0;
    logic busy_arb = 0, busy_match = 0, busy_move_in = 0, busy_move_out = 0;
    logic bit_stb = 0, rx_pin = 1, tx_eng = 0;
    logic rx_eng, tx_pin, pe_clk_en, host_clk_en;
    logic not_rdy, lpm_ack, frz_ack, stop_ack;
    logic reg_rd = 0, reg_wr = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] mem_rdata;
    logic mem_rd, mem_wr, acc_err;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign mem_rdata = {20'h5A5A0, reg_addr} ^ 32'h0000_0C3C;

    can_lp_seq i_can_lp_seq (
        .clk(clk), .rst(rst), .dis_req(dis_req), .stop_req(stop_req),
        .frz_req(frz_req), .eng_idle(eng_idle), .eng_busoff(eng_busoff),
        .ims3_rec(ims3_rec), .busy_arb(busy_arb), .busy_match(busy_match),
        .busy_move_in(busy_move_in), .busy_move_out(busy_move_out),
        .bit_stb(bit_stb), .rx_pin(rx_pin), .tx_eng(tx_eng),
        .rx_eng(rx_eng), .tx_pin(tx_pin), .pe_clk_en(pe_clk_en),
        .host_clk_en(host_clk_en), .not_rdy(not_rdy), .lpm_ack(lpm_ack),
        .frz_ack(frz_ack), .stop_ack(stop_ack), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .rdata(rdata), .acc_err(acc_err)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic set_busy(input logic [3:0] b);
        {busy_arb, busy_match, busy_move_in, busy_move_out} = b;
    endtask

    function automatic logic prot(input int a);
        return (a >= 'h010 && a <= 'h01F) || (a >= 'h080 && a <= 'h47F);
    endfunction

    task automatic strobes(input int n, input logic val);
        for (int i = 0; i < n; i++) begin
            bit_stb = 1'b1; rx_pin = val;
            step();
        end
        bit_stb = 1'b0; rx_pin = 1'b1;
    endtask

    task automatic sweep(input logic blk, input string req);
        for (int a = 0; a < (1 << AW); a++) begin
            logic p;
            p = blk && prot(a);
            reg_addr = AW'(a); reg_rd = 1'b1; reg_wr = 1'b0;
            #0.5;
            check({req, " rdata"}, rdata, p ? '0 : mem_rdata);
            check({req, " rd err"}, {31'b0, acc_err}, {31'b0, p});
            check({req, " mem_rd"}, {31'b0, mem_rd}, {31'b0, !p});
            reg_rd = 1'b0; reg_wr = 1'b1;
            #0.5;
            check({req, " mem_wr"}, {31'b0, mem_wr}, {31'b0, !p});
            check({req, " wr err"}, {31'b0, acc_err}, {31'b0, p});
        end
        reg_rd = 1'b0; reg_wr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step();
        // reset state
        check("reset lpm_ack", {31'b0, lpm_ack}, 0);
        check("reset not_rdy", {31'b0, not_rdy}, 0);
        check("reset stop_ack", {31'b0, stop_ack}, 0);
        check("reset clk_en", {30'b0, pe_clk_en, host_clk_en}, 3);
        check("reset tx", {31'b0, tx_pin}, {31'b0, tx_eng});

        // R1 R2 R3 R4 R5 R8 R9 R10: every boundary/busy pattern
        for (int bnd = 0; bnd < 8; bnd++) begin
            for (int bz = 0; bz < 16; bz++) begin
                logic ex;
                ex = (bnd != 0) && (bz == 0);
                {ims3_rec, eng_busoff, eng_idle} = 3'(bnd);
                set_busy(4'(bz));
                tx_eng = 1'b0; rx_pin = 1'b0;
                stop_req = 1'b1;
                step(3);
                check("R1 R2 lpm_ack entry", {31'b0, lpm_ack}, {31'b0, ex});
                check("R4 not_rdy entry", {31'b0, not_rdy}, {31'b0, ex});
                if (ex) begin
                    check("R3 tx recessive", {31'b0, tx_pin}, 1);
                    check("R3 rx masked", {31'b0, rx_eng}, 1);
                    check("R3 clocks gated", {30'b0, pe_clk_en, host_clk_en}, 0);
                end
                check("R5 stop_ack not early", {31'b0, stop_ack}, 0);
                step();
                check("R5 stop_ack", {31'b0, stop_ack}, {31'b0, ex});
                stop_req = 1'b0;
                step();
                check("R8 lpm_ack exit", {31'b0, lpm_ack}, 0);
                check("R5 stop_ack drop", {31'b0, stop_ack}, 0);
                if (ex) begin
                    strobes(10, 1'b1);
                    check("R10 not_rdy before gap", {31'b0, not_rdy}, 1);
                    strobes(1, 1'b1);
                    check("R9 R10 not_rdy after gap", {31'b0, not_rdy}, 0);
                    check("R3 tx follows engine", {31'b0, tx_pin}, 0);
                end
                rx_pin = 1'b1;
            end
        end
        eng_idle = 1'b1; eng_busoff = 1'b0; ims3_rec = 1'b0; set_busy(4'h0);

        // R9: dominant sample at every position of the gap
        for (int p = 0; p < 11; p++) begin
            dis_req = 1'b1;
            step(3);
            check("R4 disable entry", {31'b0, lpm_ack}, 1);
            dis_req = 1'b0;
            step();
            strobes(p, 1'b1);
            bit_stb = 1'b0; rx_pin = 1'b0;
            step();
            strobes(1, 1'b0);
            strobes(10, 1'b1);
            check("R9 dominant restarts count", {31'b0, not_rdy}, 1);
            strobes(1, 1'b1);
            check("R9 gap complete", {31'b0, not_rdy}, 0);
        end

        // R6: stop during freeze skips the bus wait
        frz_req = 1'b1;
        step();
        check("R6 frz_ack", {31'b0, frz_ack}, 1);
        eng_idle = 1'b0; set_busy(4'hF);
        stop_req = 1'b1;
        step();
        check("R6 lpm_ack shortcut", {31'b0, lpm_ack}, 1);
        check("R6 frz_ack cleared", {31'b0, frz_ack}, 0);
        check("R6 stop_ack waits", {31'b0, stop_ack}, 0);
        step();
        check("R6 stop_ack", {31'b0, stop_ack}, 1);
        // R7: stop mode blocks nothing
        sweep(1'b0, "R7 stop mode");
        stop_req = 1'b0;
        step();
        check("R8 exit from freeze entry", {31'b0, lpm_ack}, 0);
        strobes(11, 1'b1);
        check("R10 not_rdy held by freeze", {31'b0, not_rdy}, 1);
        frz_req = 1'b0;
        step(2);
        check("R10 not_rdy after freeze drop", {31'b0, not_rdy}, 0);
        eng_idle = 1'b1; set_busy(4'h0);

        // R7: run mode then disable mode
        sweep(1'b0, "R7 run mode");
        dis_req = 1'b1;
        step(3);
        check("R7 in disable", {31'b0, lpm_ack}, 1);
        check("R5 no stop_ack for disable", {31'b0, stop_ack}, 0);
        sweep(1'b1, "R7 disable mode");
        dis_req = 1'b0;
        step();
        check("R8 disable exit", {31'b0, lpm_ack}, 0);
        strobes(11, 1'b1);
        check("R10 final not_rdy", {31'b0, not_rdy}, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule